// File: doc/BRIEF.md
# ADC Result Window Watchdog

This block sits beside an analog-to-digital converter and inspects each conversion result as it is produced. It holds four watchdog units. Each unit is assigned one of sixteen input channels and a pair of bounds. When a valid result arrives on a unit's channel and lies above that unit's upper bound or below its lower bound, the unit latches a status flag. Upper and lower crossings have separate flags.

Software reads the latched flags from one status register and clears them by writing ones. An interrupt line is raised while any flag is set and that flag's interrupt is enabled. A flag interrupts only if two mask bits are set. The first is the flag's own bit in the watchdog mask. The second is the bit for the unit's channel in a per-channel mask. A unit watches only the upper side, only the lower side, or both, depending on which of its two watchdog mask bits are set. Clearing its enable bit turns the unit off.

Top module: `adc_limit_watch`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: An enabled unit sets its upper flag one clock after a valid result on its channel that is strictly greater than its upper bound. A result equal to the bound sets nothing.
- R3: An enabled unit sets its lower flag one clock after a valid result on its channel that is strictly less than its lower bound. A result equal to the bound sets nothing.
- R4: A unit whose enable bit is clear sets no flag. A unit also ignores results on channels other than its own.
- R5: Several units may watch the same channel with different bounds, and each one flags independently.
- R6: In the status register (address 0), bit i is the lower flag of unit i and bit 4+i is the upper flag of unit i. The watchdog mask (address 1) uses the same bit layout.
- R7: Writing to the status register clears exactly the flags whose bits are written as one. Writing all ones clears every flag. Flags stay set until they are cleared.
- R8: If a crossing and a clear of the same flag fall in the same cycle, the flag ends up set.
- R9: A flag drives `irq` only while its watchdog mask bit is set.
- R10: A flag drives `irq` only while the per-channel mask (address 2, bit c for channel c) has the bit of its unit's channel set.
- R11: The control register of unit i is at address 4+i, with the enable bit at bit 15 and the channel in bits 3:0. The bounds register of unit i is at address 8+i, with the upper bound in bits 31:16 and the lower bound in bits 15:0. Both read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | A conversion result is present this cycle |
| res_chan | input | 4 | Channel of the result |
| res_data | input | 16 | Result value, unsigned |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| irq | output | 1 | Watchdog interrupt |

## Verification
The bench applies results exactly equal to each bound. A comparator that used inclusive limits would raise flags on those results. Two enabled units share one channel and a disabled third unit also watches it, so logic that keys on the channel alone, or that ignores the enable bit, shows up as wrong bits in the status register. One test writes a partial clear, and another issues a clear in the same cycle as a fresh crossing. A clear that acted on every flag, or a clear that beat the new event, leaves a status value different from the expected one. Flags on a channel whose per-channel mask bit is clear, and flags whose own mask bit is clear, must not raise `irq`.

// File: rtl/adc_limit_watch.sv
module adc_limit_watch #(
  parameter int UNITS = 4,
  parameter int CHANS = 16,
  parameter int DW    = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_valid,
  input  logic [3:0]    res_chan,
  input  logic [DW-1:0] res_data,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq
);
  localparam int CW        = $clog2(CHANS);
  localparam int SW        = 2 * UNITS;
  localparam int A_STAT    = 0;
  localparam int A_WMASK   = 1;
  localparam int A_CMASK   = 2;
  localparam int CTRL_BASE = 4;
  localparam int THR_BASE  = CTRL_BASE + UNITS;
  localparam int EN_BIT    = 15;

  logic [SW-1:0]    stat_q, wmask_q, ev, chan_ok;
  logic [CHANS-1:0] cmask_q;
  logic [UNITS-1:0] en_q;
  logic [CW-1:0]    chan_q [UNITS];
  logic [DW-1:0]    hi_q   [UNITS];
  logic [DW-1:0]    lo_q   [UNITS];

  wire wr_stat = reg_wr && (reg_addr == AW'(A_STAT));
  wire [SW-1:0] clr = wr_stat ? reg_wdata[SW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      wmask_q <= '0;
      cmask_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | ev;
      if (reg_wr && reg_addr == AW'(A_WMASK)) wmask_q <= reg_wdata[SW-1:0];
      if (reg_wr && reg_addr == AW'(A_CMASK)) cmask_q <= reg_wdata[CHANS-1:0];
    end
  end

  genvar u;
  generate
    for (u = 0; u < UNITS; u++) begin : g_unit
      wire hit = res_valid && en_q[u] && (res_chan[CW-1:0] == chan_q[u]);
      assign ev[u]           = hit && (res_data < lo_q[u]);
      assign ev[UNITS+u]     = hit && (res_data > hi_q[u]);
      assign chan_ok[u]       = cmask_q[chan_q[u]];
      assign chan_ok[UNITS+u] = cmask_q[chan_q[u]];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q[u]   <= 1'b0;
          chan_q[u] <= '0;
          hi_q[u]   <= '0;
          lo_q[u]   <= '0;
        end else if (reg_wr) begin
          if (reg_addr == AW'(CTRL_BASE + u)) begin
            en_q[u]   <= reg_wdata[EN_BIT];
            chan_q[u] <= reg_wdata[CW-1:0];
          end
          if (reg_addr == AW'(THR_BASE + u)) begin
            hi_q[u] <= reg_wdata[16 +: DW];
            lo_q[u] <= reg_wdata[0 +: DW];
          end
        end
      end

      // R4
      off_unit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q[u] && !stat_q[u] && !stat_q[UNITS+u])
          |=> (!stat_q[u] && !stat_q[UNITS+u]));

      // R2
      high_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && en_q[u] && res_chan[CW-1:0] == chan_q[u] && res_data > hi_q[u])
          |=> stat_q[UNITS+u]);

      // R3
      low_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && en_q[u] && res_chan[CW-1:0] == chan_q[u] && res_data < lo_q[u])
          |=> stat_q[u]);
    end
  endgenerate

  assign irq = |(stat_q & wmask_q & chan_ok);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(A_STAT))  reg_rdata[SW-1:0]    = stat_q;
    if (reg_addr == AW'(A_WMASK)) reg_rdata[SW-1:0]    = wmask_q;
    if (reg_addr == AW'(A_CMASK)) reg_rdata[CHANS-1:0] = cmask_q;
    for (int i = 0; i < UNITS; i++) begin
      if (reg_addr == AW'(CTRL_BASE + i)) begin
        reg_rdata[EN_BIT]  = en_q[i];
        reg_rdata[CW-1:0]  = chan_q[i];
      end
      if (reg_addr == AW'(THR_BASE + i))
        reg_rdata = {hi_q[i], lo_q[i]};
    end
  end

  genvar b;
  generate
    for (b = 0; b < SW; b++) begin : g_bit
      // R7
      flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[b] && !(wr_stat && reg_wdata[b])) |=> stat_q[b]);

      // R7
      flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && reg_wdata[b] && !ev[b]) |=> !stat_q[b]);

      // R8
      event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && reg_wdata[b] && ev[b]) |=> stat_q[b]);
    end
  endgenerate

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(stat_q & wmask_q)));
endmodule

// File: tb/adc_limit_watch_bench.sv
`timescale 1ns/1ps
module adc_limit_watch_bench;
  logic clk = 0, rst_n = 0;
  logic res_valid = 0;
  logic [3:0] res_chan = 0;
  logic [15:0] res_data = 0;
  logic reg_wr = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic irq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  adc_limit_watch u_adc_limit_watch (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
    .res_data(res_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  // {chan[4], data[16], expected status[8], expected irq[1]}
  localparam int NV = 9;
  localparam logic [28:0] VEC [NV] = '{
    {4'd3, 16'd1000,   8'h40, 1'b1},  // R2 equal upper bound of unit 0, unit 2 above
    {4'd3, 16'd1001,   8'h50, 1'b1},  // R2 R5
    {4'd3, 16'd100,    8'h04, 1'b1},  // R3 equal lower bound of unit 0
    {4'd3, 16'd99,     8'h05, 1'b1},  // R3 R5
    {4'd3, 16'd450,    8'h00, 1'b0},  // R4 inside all windows
    {4'd7, 16'hFFFF,   8'h20, 1'b0},  // R6 R10 unit 1 upper, channel masked
    {4'd7, 16'h000F,   8'h02, 1'b0},  // R6 R10 unit 1 lower
    {4'd5, 16'd0,      8'h00, 1'b0},  // R4 unwatched channel
    {4'd7, 16'h0010,   8'h00, 1'b0}   // R3 equal lower bound of unit 1
  };

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic sample(logic [3:0] c, logic [15:0] v);
    @(negedge clk);
    res_valid = 1; res_chan = c; res_data = v;
    @(negedge clk);
    res_valid = 0;
  endtask

  initial begin
    logic [31:0] d;
    #1;
    rd(4'd0, d); chk("R1 status", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    rd(4'd0, d); chk("R1 status", d, 0);
    rd(4'd4, d); chk("R1 ctrl0", d, 0);
    rd(4'd9, d); chk("R1 bounds1", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    wr(4'd4, 32'h0000_8003);
    wr(4'd5, 32'h0000_8007);
    wr(4'd6, 32'h0000_8003);
    wr(4'd7, 32'h0000_0003);
    wr(4'd8, {16'd1000, 16'd100});
    wr(4'd9, {16'h8000, 16'h0010});
    wr(4'd10, {16'd500, 16'd400});
    wr(4'd11, {16'd0, 16'hFFFF});
    wr(4'd1, 32'hFF);
    wr(4'd2, 32'h0008);
    rd(4'd4, d); chk("R11 ctrl0", d, 32'h0000_8003);
    rd(4'd7, d); chk("R11 ctrl3", d, 32'h0000_0003);
    rd(4'd9, d); chk("R11 bounds1", d, 32'h8000_0010);
    rd(4'd2, d); chk("R11 chan mask", d, 32'h0000_0008);

    for (int i = 0; i < NV; i++) begin
      sample(VEC[i][28:25], VEC[i][24:9]);
      rd(4'd0, d); chk($sformatf("R2/R3/R4 vector %0d status", i), d, {24'b0, VEC[i][8:1]});
      chk($sformatf("R10 vector %0d irq", i), {31'b0, irq}, {31'b0, VEC[i][0]});
      wr(4'd0, 32'hFFFF_FFFF);
      rd(4'd0, d); chk($sformatf("R7 vector %0d cleared", i), d, 0);
    end

    sample(4'd3, 16'd1001);
    wr(4'd0, 32'h10);
    rd(4'd0, d); chk("R7 partial clear", d, 32'h40);
    wr(4'd0, 32'hFF);

    sample(4'd3, 16'd99);
    @(negedge clk);
    res_valid = 1; res_chan = 4'd3; res_data = 16'd1001;
    reg_wr = 1; reg_addr = 4'd0; reg_wdata = 32'hFF;
    @(negedge clk);
    res_valid = 0; reg_wr = 0;
    rd(4'd0, d); chk("R8 event beats clear", d, 32'h50);

    wr(4'd1, 32'h0F);
    chk("R9 high flags masked", {31'b0, irq}, 0);
    sample(4'd3, 16'd0);
    chk("R9 low flag unmasked", {31'b0, irq}, 1);
    wr(4'd2, 32'h0);
    chk("R10 channel masked", {31'b0, irq}, 0);
    rd(4'd0, d); chk("R6 status unaffected by masks", d, 32'h55);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule